// File: doc/BRIEF.md
# Addressed Three-Wire Control Port

This block is the serial slave port of a tuner synthesizer. A host controls it over three lines: a chip-enable, a serial clock and a data-in line. A fourth line, data-out, is open-drain. All three host lines are resynchronised into the system clock, and every bit is taken on a detected rising edge of the serial clock.

A transfer has two phases. While chip-enable is low, the host shifts in an 8-bit address. Chip-enable then rises and the data phase begins. Two address codes load one of two 24-bit control registers. The new contents are applied only when chip-enable falls, and only if exactly 24 bits arrived. A third code starts a status readout. In the readout, one bit leaves per serial clock: first the two port-pin states, then a sticky lock flag, then a 20-bit measurement count, most significant bit first.

Outside a transfer, the data-out line is not silent. A 3-bit select field in control register B picks what drives it: the live unlock signal, a measurement-complete indicator, or an echo of one of the two port pins.

Top module: `tsw_ctrl_port`

## Requirements
- R1: Addresses are shifted in with chip-enable low, first bit first. Read with the first bit as the most significant bit, 8'h14 selects a load of register A, 8'h94 a load of register B and 8'h54 a readout.
- R2: A load takes effect only at the falling edge of chip-enable, and only if exactly 24 data bits were clocked in. The first data bit lands in register bit 0. Any other bit count leaves both registers unchanged.
- R3: A transfer under any other address changes neither register.
- R4: A readout sends 23 bits on data-out: IO1, IO2, the lock bit, then count[19] down to count[0]. A 0 bit pulls the line low. The first bit appears after chip-enable rises, and each serial clock rising edge advances one bit. Pins and count are captured at entry. After the last bit the line is open.
- R5: The lock bit reads 0 once unlock_i has been high at any point since the end of the last recognised transfer. Otherwise it reads 1. The end of any recognised transfer re-arms it.
- R6: While chip-enable is high under a load or an unknown address, data-out is open whatever the select field says.
- R7: With chip-enable low, the select field ctrl_b[2:0] drives data-out as follows. 001 pulls the line low while unlock_i is high. 010 shows the completion indicator. 101 echoes IO1 and 110 echoes IO2, with a low pin pulling the line low. Every other code leaves the line open.
- R8: A pin echo is open when that pin is marked as an output: ctrl_b[3] for IO1, ctrl_b[4] for IO2.
- R9: The completion indicator is released when a load of B raises the count-run bit ctrl_b[5] from 0 to 1. It pulls the line low after a cnt_done_i pulse and stays low until the next such rise.
- R10: After reset both registers are zero and data-out is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Chip-enable from host (asynchronous) |
| sclk_i | input | 1 | Serial clock from host (asynchronous) |
| sdi_i | input | 1 | Serial data from host (asynchronous) |
| io1_i | input | 1 | Port pin 1 level |
| io2_i | input | 1 | Port pin 2 level |
| unlock_i | input | 1 | Unlock detector output, high when unlocked |
| cnt_done_i | input | 1 | One-cycle pulse when a measurement finishes |
| cnt_val_i | input | 20 | Measurement count value |
| sdo_pull_o | output | 1 | Open-drain data-out: 1 pulls the line low |
| ctrl_a_o | output | 24 | Control register A |
| ctrl_b_o | output | 24 | Control register B (select, directions, count-run) |

## Verification
The internal state shows at the ports in the following ways:
- A corrupted address shift register or bit counter shows up at the next chip-enable fall. A control register either fails to take a complete load or takes a short or long one.
- A stuck sticky flag appears in the lock bit of the next readout, or in the one after it.
- Frame shifting errors move a count bit to the wrong clock within the same readout.
- Errors in the idle multiplexer or the completion flag show on data-out within a few system clocks of a pin, unlock or done change.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_LOAD_A = 8'h14;
  localparam logic [ADDR_W-1:0] ADDR_LOAD_B = 8'h94;
  localparam logic [ADDR_W-1:0] ADDR_READ   = 8'h54;

  localparam int SEL_W       = 3;
  localparam int SEL_LSB     = 0;
  localparam int IO1_DIR_BIT = 3;
  localparam int IO2_DIR_BIT = 4;
  localparam int RUN_BIT     = 5;

  localparam logic [SEL_W-1:0] SEL_UNLOCK = 3'b001;
  localparam logic [SEL_W-1:0] SEL_DONE   = 3'b010;
  localparam logic [SEL_W-1:0] SEL_ECHO1  = 3'b101;
  localparam logic [SEL_W-1:0] SEL_ECHO2  = 3'b110;

  typedef enum logic [1:0] {XF_NONE, XF_LOAD_A, XF_LOAD_B, XF_READ} xfer_e;

  function automatic xfer_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      ADDR_LOAD_A: return XF_LOAD_A;
      ADDR_LOAD_B: return XF_LOAD_B;
      ADDR_READ:   return XF_READ;
      default:     return XF_NONE;
    endcase
  endfunction
endpackage

// File: rtl/tsw_sync.sv
module tsw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_st
      logic [W-1:0] q;
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) q <= '0;
          else         q <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) q <= '0;
          else         q <= g_st[s-1].q;
      end
    end
  endgenerate

  assign q_o = g_st[STAGES-1].q;
endmodule

// File: rtl/tsw_rx.sv
module tsw_rx import tsw_pkg::*; #(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output xfer_e             xfer_o,
  output logic              start_o,
  output logic              end_o,
  output logic              sclk_rise_o,
  output logic              run_start_o,
  output logic [DATA_W-1:0] ctrl_a_o,
  output logic [DATA_W-1:0] ctrl_b_o
);
  localparam int BIT_CW = $clog2(DATA_W + 2);
  localparam logic [BIT_CW-1:0] BITS_FULL = BIT_CW'(DATA_W);
  localparam logic [BIT_CW-1:0] BITS_SAT  = BIT_CW'(DATA_W + 1);

  logic              ce_q, sclk_q, start_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, ctrl_a_q, ctrl_b_q;
  logic [BIT_CW-1:0] bit_q;
  xfer_e             xfer_q;

  logic ce_rise, ce_fall, sck_rise, in_load, full_ok;
  assign ce_rise  = ce_i & ~ce_q;
  assign ce_fall  = ~ce_i & ce_q;
  assign sck_rise = sclk_i & ~sclk_q;
  assign in_load  = (xfer_q == XF_LOAD_A) || (xfer_q == XF_LOAD_B);
  assign full_ok  = (bit_q == BITS_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q     <= 1'b0;
      sclk_q   <= 1'b0;
      start_q  <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      bit_q    <= '0;
      xfer_q   <= XF_NONE;
      ctrl_a_q <= '0;
      ctrl_b_q <= '0;
    end else begin
      ce_q    <= ce_i;
      sclk_q  <= sclk_i;
      start_q <= ce_rise;
      if (ce_rise) begin
        xfer_q <= decode_addr(addr_q);
        addr_q <= '0;
        bit_q  <= '0;
      end else if (!ce_i && sck_rise) begin
        addr_q <= {addr_q[ADDR_W-2:0], sdi_i};
      end
      if (ce_i && sck_rise && in_load) begin
        data_q <= {sdi_i, data_q[DATA_W-1:1]};
        if (bit_q != BITS_SAT) bit_q <= bit_q + BIT_CW'(1);
      end
      if (ce_fall) begin
        xfer_q <= XF_NONE;
        if (full_ok && xfer_q == XF_LOAD_A) ctrl_a_q <= data_q;
        if (full_ok && xfer_q == XF_LOAD_B) ctrl_b_q <= data_q;
      end
    end
  end

  assign xfer_o      = xfer_q;
  assign start_o     = start_q;
  assign end_o       = ce_fall && (xfer_q != XF_NONE);
  assign sclk_rise_o = sck_rise;
  assign run_start_o = ce_fall && full_ok && (xfer_q == XF_LOAD_B)
                       && data_q[RUN_BIT] && !ctrl_b_q[RUN_BIT];
  assign ctrl_a_o    = ctrl_a_q;
  assign ctrl_b_o    = ctrl_b_q;

  // R2: registers only move on the chip-enable fall
  a_r2_hold_while_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |=> ($stable(ctrl_a_q) && $stable(ctrl_b_q)));
  a_r2_short_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_fall && bit_q != BITS_FULL) |=> ($stable(ctrl_a_q) && $stable(ctrl_b_q)));
  a_r3_unknown_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_fall && xfer_q == XF_NONE) |=> ($stable(ctrl_a_q) && $stable(ctrl_b_q)));
endmodule

// File: rtl/tsw_tx.sv
module tsw_tx import tsw_pkg::*; #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  xfer_e            xfer_i,
  input  logic             start_i,
  input  logic             end_i,
  input  logic             sclk_rise_i,
  input  logic             run_start_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             io1_out_i,
  input  logic             io2_out_i,
  input  logic             unlock_i,
  input  logic             cnt_done_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  input  logic             io1_i,
  input  logic             io2_i,
  output logic             pull_o
);
  localparam int FRAME_W = CNT_W + 3;

  logic               unl_q, done_q, idle_pull;
  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unl_q   <= 1'b0;
      done_q  <= 1'b0;
      frame_q <= '1;
    end else begin
      if (unlock_i)   unl_q <= 1'b1;
      else if (end_i) unl_q <= 1'b0;

      if (cnt_done_i)       done_q <= 1'b1;
      else if (run_start_i) done_q <= 1'b0;

      if (start_i && xfer_i == XF_READ)
        frame_q <= {io1_i, io2_i, ~unl_q, cnt_val_i};
      else if (ce_i && xfer_i == XF_READ && sclk_rise_i)
        frame_q <= {frame_q[FRAME_W-2:0], 1'b1};
      else if (end_i)
        frame_q <= '1;
    end
  end

  always_comb begin
    idle_pull = 1'b0;
    case (sel_i)
      SEL_UNLOCK: idle_pull = unlock_i;
      SEL_DONE:   idle_pull = done_q;
      SEL_ECHO1:  idle_pull = !io1_out_i && !io1_i;
      SEL_ECHO2:  idle_pull = !io2_out_i && !io2_i;
      default:    idle_pull = 1'b0;
    endcase
  end

  assign pull_o = ce_i ? ((xfer_i == XF_READ) && !frame_q[FRAME_W-1]) : idle_pull;

  a_r5_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_i |=> unl_q);
  a_r9_done_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_done_i |=> done_q);
  a_r6_load_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && xfer_i != XF_READ) |-> !pull_o);
  a_r8_echo1_out_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i && sel_i == SEL_ECHO1 && io1_out_i) |-> !pull_o);
  a_r8_echo2_out_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i && sel_i == SEL_ECHO2 && io2_out_i) |-> !pull_o);
endmodule

// File: rtl/tsw_ctrl_port.sv
module tsw_ctrl_port import tsw_pkg::*; #(
  parameter int DATA_W      = 24,
  parameter int CNT_W       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              io1_i,
  input  logic              io2_i,
  input  logic              unlock_i,
  input  logic              cnt_done_i,
  input  logic [CNT_W-1:0]  cnt_val_i,
  output logic              sdo_pull_o,
  output logic [DATA_W-1:0] ctrl_a_o,
  output logic [DATA_W-1:0] ctrl_b_o
);
  logic [2:0] host_s;
  logic [1:0] pin_s;
  xfer_e      xfer;
  logic       start, xend, sck_rise, run_start;

  tsw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_host_sync (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .d_i   ({ce_i, sclk_i, sdi_i}), .q_o(host_s)
  );

  tsw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .d_i   ({io1_i, io2_i}), .q_o(pin_s)
  );

  tsw_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_i        (host_s[2]),
    .sclk_i      (host_s[1]),
    .sdi_i       (host_s[0]),
    .xfer_o      (xfer),
    .start_o     (start),
    .end_o       (xend),
    .sclk_rise_o (sck_rise),
    .run_start_o (run_start),
    .ctrl_a_o    (ctrl_a_o),
    .ctrl_b_o    (ctrl_b_o)
  );

  tsw_tx #(.CNT_W(CNT_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_i        (host_s[2]),
    .xfer_i      (xfer),
    .start_i     (start),
    .end_i       (xend),
    .sclk_rise_i (sck_rise),
    .run_start_i (run_start),
    .sel_i       (ctrl_b_o[SEL_LSB +: SEL_W]),
    .io1_out_i   (ctrl_b_o[IO1_DIR_BIT]),
    .io2_out_i   (ctrl_b_o[IO2_DIR_BIT]),
    .unlock_i    (unlock_i),
    .cnt_done_i  (cnt_done_i),
    .cnt_val_i   (cnt_val_i),
    .io1_i       (pin_s[1]),
    .io2_i       (pin_s[0]),
    .pull_o      (sdo_pull_o)
  );
endmodule

// File: tb/tb_tsw_ctrl_port.sv
module tb_tsw_ctrl_port;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 24;
  localparam int CNT_W  = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b0, sclk = 1'b0, sdi = 1'b0, io1 = 1'b0, io2 = 1'b0;
  logic unlock = 1'b0, cnt_done = 1'b0;
  logic [CNT_W-1:0]  cnt_val = '0;
  logic              sdo_pull;
  logic [DATA_W-1:0] ctrl_a, ctrl_b;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [DATA_W-1:0] ctrl_a_m = '0, ctrl_b_m = '0;
  logic unl_m = 0, done_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsw_ctrl_port dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sclk_i(sclk), .sdi_i(sdi),
    .io1_i(io1), .io2_i(io2), .unlock_i(unlock), .cnt_done_i(cnt_done),
    .cnt_val_i(cnt_val), .sdo_pull_o(sdo_pull), .ctrl_a_o(ctrl_a), .ctrl_b_o(ctrl_b)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic line();
    return !sdo_pull;
  endfunction

  function automatic logic exp_line();
    case (ctrl_b_m[2:0])
      3'b001:  return !unlock;
      3'b010:  return !done_m;
      3'b101:  return ctrl_b_m[3] ? 1'b1 : io1;
      3'b110:  return ctrl_b_m[4] ? 1'b1 : io2;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit known(input logic [7:0] a);
    return a == 8'h14 || a == 8'h94 || a == 8'h54;
  endfunction

  task automatic clk_bit(input logic b);
    sdi = b; wait_n(3);
    sclk = 1'b1; wait_n(6);
    sclk = 1'b0; wait_n(3);
  endtask

  task automatic set_unlock(input logic v);
    unlock = v;
    if (v) unl_m = 1'b1;
  endtask

  task automatic pulse_done();
    cnt_done = 1'b1; wait_n(1); cnt_done = 1'b0;
    done_m = 1'b1;
  endtask

  task automatic run_xfer(input logic [7:0] a, input logic [DATA_W-1:0] d,
                          input int nbits, input bit mid_chk);
    ce = 1'b0;
    for (int i = 7; i >= 0; i--) clk_bit(a[i]);
    wait_n(3); ce = 1'b1; wait_n(6);
    for (int i = 0; i < nbits; i++) begin
      clk_bit(i < DATA_W ? d[i] : 1'b0);
      if (mid_chk && i == 11) check("R6 open during load", line(), 1'b1);
    end
    wait_n(3); ce = 1'b0; wait_n(8);
    if (a == 8'h14 && nbits == DATA_W) ctrl_a_m = d;
    if (a == 8'h94 && nbits == DATA_W) begin
      if (d[5] && !ctrl_b_m[5]) done_m = 1'b0;
      ctrl_b_m = d;
    end
    if (known(a)) unl_m = unlock;
  endtask

  task automatic read_chk(input string tag);
    logic [22:0] got, exp;
    logic tail;
    exp = {io1, io2, ~unl_m, cnt_val};
    ce = 1'b0;
    for (int i = 7; i >= 0; i--) clk_bit(8'h54 >> i);
    wait_n(3); ce = 1'b1; wait_n(10);
    got[22] = line();
    for (int k = 21; k >= 0; k--) begin
      sclk = 1'b1; wait_n(6); sclk = 1'b0; wait_n(6);
      got[k] = line();
    end
    sclk = 1'b1; wait_n(6); sclk = 1'b0; wait_n(6);
    tail = line();
    ce = 1'b0; wait_n(8);
    unl_m = unlock;
    check({tag, " frame"}, 64'(got), 64'(exp));
    check("R4 open after frame", tail, 1'b1);
  endtask

  task automatic load_b(input logic [DATA_W-1:0] d);
    run_xfer(8'h94, d, DATA_W, 0);
  endtask

  task automatic chk_regs(input string tag);
    check({tag, " ctrl_a"}, ctrl_a, ctrl_a_m);
    check({tag, " ctrl_b"}, ctrl_b, ctrl_b_m);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    wait_n(4);
    check("R10 reset ctrl_a", ctrl_a, 0);
    check("R10 reset ctrl_b", ctrl_b, 0);
    check("R10 reset line open", line(), 1'b1);
    rst_n = 1'b1; wait_n(4);

    run_xfer(8'h14, 24'hA53C0F, DATA_W, 0);
    chk_regs("R1 R2 load A");
    load_b(24'h000000);
    run_xfer(8'h94, 24'h5A0000, DATA_W, 0);
    chk_regs("R1 load B");

    run_xfer(8'h14, 24'h123456, 23, 0);
    chk_regs("R2 short load ignored");
    run_xfer(8'h14, 24'h654321, 25, 0);
    chk_regs("R2 long load ignored");
    run_xfer(8'h15, 24'hFFFFFF, DATA_W, 0);
    chk_regs("R3 unknown addr 15");
    run_xfer(8'h55, 24'hFFFFFF, DATA_W, 0);
    chk_regs("R3 unknown addr 55");

    io1 = 1'b1; io2 = 1'b0; cnt_val = 20'h53980; wait_n(4);
    read_chk("R4 readout");
    io1 = 1'b0; io2 = 1'b1; cnt_val = 20'h00E10; wait_n(4);
    read_chk("R4 readout 2");

    set_unlock(1'b1); wait_n(2); set_unlock(1'b0);
    read_chk("R5 sticky low");
    read_chk("R5 rearmed");

    load_b(24'h000001);
    set_unlock(1'b1); wait_n(3);
    check("R7 unlock pulls low", line(), exp_line());
    run_xfer(8'h94, 24'h000001, DATA_W, 1);
    run_xfer(8'h33, 24'h000001, 8, 1);
    set_unlock(1'b0); wait_n(3);
    check("R7 unlock released", line(), exp_line());

    load_b(24'h000022); wait_n(2);
    check("R9 released on start", line(), 1'b1);
    pulse_done(); wait_n(2);
    check("R9 low on done", line(), 1'b0);
    load_b(24'h000022);
    check("R9 no rise keeps low", line(), 1'b0);
    load_b(24'h000002);
    check("R9 run cleared keeps low", line(), 1'b0);
    load_b(24'h000022);
    check("R9 rerun releases", line(), 1'b1);

    load_b(24'h00000D); io1 = 1'b0; wait_n(5);
    check("R8 echo1 out open", line(), 1'b1);
    load_b(24'h000005); wait_n(5);
    check("R7 echo1 low", line(), 1'b0);
    io1 = 1'b1; wait_n(5);
    check("R7 echo1 high", line(), 1'b1);
    load_b(24'h000016); io2 = 1'b0; wait_n(5);
    check("R8 echo2 out open", line(), 1'b1);
    load_b(24'h000006); wait_n(5);
    check("R7 echo2 low", line(), 1'b0);

    for (int it = 0; it < 40; it++) begin
      int act;
      logic [7:0] a;
      logic [DATA_W-1:0] d;
      act = $urandom_range(0, 4);
      d = DATA_W'($urandom);
      case (act)
        0: run_xfer(8'h14, d, DATA_W, 0);
        1: run_xfer(8'h94, d, DATA_W, 0);
        2: run_xfer(($urandom_range(0, 1) != 0) ? 8'h14 : 8'h94, d,
                    ($urandom_range(0, 1) != 0) ? 23 : 25, 0);
        3: begin
          a = 8'($urandom);
          if (known(a)) a = a ^ 8'h01;
          run_xfer(a, d, DATA_W, 0);
        end
        default: begin
          cnt_val = CNT_W'($urandom); wait_n(2);
          read_chk("R4 R5 random readout");
        end
      endcase
      chk_regs("R1 R2 R3 random");
      io1 = 1'($urandom); io2 = 1'($urandom);
      set_unlock(1'($urandom));
      if ($urandom_range(0, 3) == 0) pulse_done();
      wait_n(6);
      check("R7 R8 R9 random idle", line(), exp_line());
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule